// File: doc/BRIEF.md
# Bit-Reversed Pulse-Density Modulator

This block turns an unsigned duty word into a one-bit stream whose long-term average equals duty divided by 2^W. A W-bit counter runs freely and advances on every clock. A magnitude comparator decides each output cycle by testing a comparison value against the active duty word. The output is high while the comparison value is below the duty word.

The comparison value comes from the counter in one of two ways. In spread mode it is the counter with its bit order mirrored, so the high cycles are scattered evenly over the period. The output then needs only a light analog low-pass filter. In plain mode the counter is used unchanged, which gives ordinary edge-aligned PWM with a single pulse at the start of each period.

The duty word and the mode are sampled only on the last cycle of a period. Every period therefore runs with one duty value and one mode from start to end.

Top module: `pulse_spreader`

## Requirements
- R1: While reset is asserted and afterwards, until the first period boundary has passed, pulse_o is 0: the counter starts at 0, the active duty word starts at 0 and the active mode starts at plain.
- R2: The counter advances by one on every clock and wraps from 2^W-1 to 0. pulse_o is registered: in the cycle after the counter holds value k, pulse_o shows the decision for slot k.
- R3: In spread mode (spread_i = 1) the comparison value has bit i equal to counter bit W-1-i. For W = 3 the comparison values over slots 0..7 are 0, 4, 2, 6, 1, 5, 3, 7. The output for a slot is 1 exactly when its comparison value is less than the active duty.
- R4: In plain mode (spread_i = 0) the comparison value equals the counter, so slots 0..duty-1 are high and the rest of the period is low.
- R5: In either mode each period contains exactly duty high cycles, and a duty of 0 keeps pulse_o low for the whole period.
- R6: A new duty_i value is taken into use only when the counter wraps from 2^W-1 to 0. A change in the middle of a period leaves the remainder of that period unchanged.
- R7: A new spread_i value is taken into use only at the same wrap point, and it never changes the mode within a period.
- R8: In spread mode with duty = 2^(W-1), the output alternates high and low, so no two adjacent cycles are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_i | input | W | Requested number of high cycles per period |
| spread_i | input | 1 | 1 selects bit-mirrored comparison, 0 selects plain PWM |
| pulse_o | output | 1 | Registered pulse-density output |

## Verification
Two events can land in the same cycle: a change of duty and a change of mode both reaching the wrap point, or a change that arrives on the last slot of a period. The bench changes duty and mode together in the cycle where the counter holds its final value. It then expects the period that is completing to keep the old pattern and the next period to show the new one. A cycle-accurate model in the bench predicts every output cycle. Each completed period is also compared against a hand-derived slot pattern.

// File: rtl/pulse_spreader.sv
module pulse_spreader #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_i,
  input  logic         spread_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt;
  logic [W-1:0] duty_q;
  logic         spread_q;
  logic [W-1:0] mirror;
  logic [W-1:0] cmp;
  logic         wrap;

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirror[i] = cnt[W-1-i];
  end

  assign cmp  = spread_q ? mirror : cnt;
  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_q   <= '0;
      spread_q <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      cnt     <= cnt + W'(1);
      pulse_o <= (cmp < duty_q);
      if (wrap) begin
        duty_q   <= duty_i;
        spread_q <= spread_i;
      end
    end
  end
endmodule

// File: rtl/pulse_spreader_chk.sv
module pulse_spreader_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] duty_q,
  input logic         spread_q,
  input logic         pulse_o
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == W'($past(cnt) + W'(1))); // R2
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q == '0 |=> !pulse_o); // R5
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != LAST |=> $stable(duty_q)); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != LAST |=> $stable(spread_q)); // R7
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && duty_q != '0) |=> pulse_o); // R3
endmodule

bind pulse_spreader pulse_spreader_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .duty_q(duty_q),
  .spread_q(spread_q), .pulse_o(pulse_o)
);

// File: tb/pulse_spreader_bench.sv
`timescale 1ns/1ps
module pulse_spreader_bench;
  localparam int W = 3;
  localparam int P = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] duty_i = '0;
  logic spread_i = 1'b0;
  wire  pulse_o;

  pulse_spreader #(.W(W)) u_pulse_spreader (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .spread_i(spread_i), .pulse_o(pulse_o)
  );

  always #2.5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  int m_cnt = 0, m_duty = 0, m_mode = 0;
  int exp_p = 0, slot = 0, cur_duty = 0, cur_mode = 0, valid = 0;
  int per_done = 0;
  logic [P-1:0] bits = '0;
  logic [P-1:0] last_pat = '0;

  function automatic int mirror(input int v);
    int r = 0;
    for (int i = 0; i < W; i++) if (v[i]) r = r | (1 << (W-1-i));
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_mode = 0; valid = 0;
    end else begin
      int a;
      a = m_mode ? mirror(m_cnt) : m_cnt;
      exp_p = (a < m_duty) ? 1 : 0;
      slot = m_cnt;
      cur_duty = m_duty;
      cur_mode = m_mode;
      if (m_cnt == P-1) begin
        m_duty = int'(duty_i);
        m_mode = int'(spread_i);
      end
      m_cnt = (m_cnt + 1) % P;
      valid = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && valid) begin
      chk(cur_mode ? "R3 spread slot (R2 lag)" : "R4 plain slot (R2 lag)", int'(pulse_o), exp_p);
      bits[slot] = pulse_o;
      if (slot == P-1) begin
        chk("R5 high count per period", $countones(bits), cur_duty);
        last_pat = bits;
        per_done++;
      end
    end
  end

  task automatic apply(input int d, input int m);
    int n;
    @(negedge clk);
    duty_i = W'(d);
    spread_i = m[0];
    n = per_done;
    wait (per_done >= n + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(pulse_o), 0);
    rst_n = 1'b1;
    wait (per_done >= 1);
    chk("R1 first period low", int'(last_pat), 0);

    apply(3, 1); chk("R3 spread duty 3", int'(last_pat), 'b0001_0101);
    apply(1, 1); chk("R3 spread duty 1", int'(last_pat), 'b0000_0001);
    apply(2, 1); chk("R3 spread duty 2", int'(last_pat), 'b0001_0001);
    apply(4, 1); chk("R8 spread half alternates", int'(last_pat), 'b0101_0101);
    apply(7, 1); chk("R3 spread duty max", int'(last_pat), 'b0111_1111);
    apply(0, 1); chk("R5 duty 0 low", int'(last_pat), 0);
    apply(3, 0); chk("R4 plain duty 3", int'(last_pat), 'b0000_0111);
    apply(7, 0); chk("R4 plain duty max", int'(last_pat), 'b0111_1111);

    begin : mid_duty
      int n;
      apply(2, 0);
      n = per_done;
      wait (per_done >= n + 1);
      repeat (3) @(negedge clk);
      duty_i = W'(6);
      n = per_done;
      wait (per_done >= n + 1);
      chk("R6 mid-period duty ignored", int'(last_pat), 'b0000_0011);
      wait (per_done >= n + 2);
      chk("R6 new duty at wrap", int'(last_pat), 'b0011_1111);
    end

    begin : mid_mode
      int n;
      apply(4, 0);
      n = per_done;
      wait (per_done >= n + 1);
      repeat (4) @(negedge clk);
      spread_i = 1'b1;
      n = per_done;
      wait (per_done >= n + 1);
      chk("R7 mid-period mode ignored", int'(last_pat), 'b0000_1111);
      wait (per_done >= n + 2);
      chk("R7 new mode at wrap", int'(last_pat), 'b0101_0101);
    end

    begin : same_cycle
      int n;
      do @(negedge clk); while (m_cnt != P-1);
      duty_i = W'(3);
      spread_i = 1'b0;
      n = per_done;
      wait (per_done >= n + 1);
      chk("R6 R7 last-slot change keeps old period", int'(last_pat), 'b0101_0101);
      wait (per_done >= n + 2);
      chk("R6 R7 last-slot change lands next period", int'(last_pat), 'b0000_0111);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule